// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a single-channel interval timer attached to a simple word-addressed 32-bit register bus. Software programs a reload value, then writes a control word whose strobe bits start or halt the counter. The counter counts down one step per clock. When it runs out it raises a sticky timeout flag, and it either halts or reloads and keeps going, depending on the mode bit held in the same control word.

The timeout flag drives a level interrupt through an enable bit. Software acknowledges the flag by writing anything to the status register. A dedicated read-only register returns the live count at any time, so software can measure elapsed time without stopping the counter. Reads return their data one cycle after the read strobe.

Top module: `interval_timer`

## Requirements
- R1: After reset, the status, control, reload and live-count registers all read as zero, the counter is halted and `irq_o` is low.
- R2: Register decode uses byte addresses: 0x0 is status, 0x4 is control, 0x8 is reload and 0xC is live count. Read data appears on `bus_rdata` in the cycle after `bus_re` and is zero in all other cycles. An address with bits [1:0] not zero, or above 0xC, reads as zero, and a write to it changes nothing.
- R3: A control write stores all 32 bits, which read back unchanged. The bits are: bit 0 interrupt enable, bit 1 auto-reload, bit 2 start, bit 3 halt. Start sets the running state. Halt clears it and freezes the count at its current value in that same cycle. When both bits are set, halt wins.
- R4: A write to the reload register stores the value and also loads it into the live counter, overriding any decrement or expiry in that cycle.
- R5: While running, the counter drops by exactly one per clock. While halted it holds its value.
- R6: A running counter holding 1 or 0 expires on the next clock edge, which sets the timeout flag (status bit 0). Status bit 1 reports the running state.
- R7: In one-shot mode (bit 1 clear) the counter holds 0 after expiry and halts.
- R8: In auto-reload mode (bit 1 set) the counter reloads the stored reload value on expiry and keeps running, so it expires once every N clocks for a reload value N.
- R9: A write of any value to status clears the timeout flag and leaves the running bit alone. If an expiry falls in the same cycle as that write, the flag stays set.
- R10: `irq_o` is high exactly when the timeout flag and the interrupt-enable bit are both set. It follows either of them with no extra delay.
- R11: Writes to the live-count register are ignored.
- R12: Starting the counter while it holds 0 gives an expiry on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | DATA_W | Read data, valid in the cycle after `bus_re` |
| irq_o | output | 1 | Level interrupt: timeout flag AND enable |

## Verification
The hardest case to reach from the ports is an acknowledge write to status that lands in the same clock as an expiry. The bench reaches it by loading a reload value of 3, starting the counter, and counting bus cycles exactly: the expiry is due on the third edge after the start write, so the status write is issued on that edge, and a following read must still show the flag. Auto-reload timing is checked with back-to-back live-count reads across two full periods. Each read result is compared against a closed-form position in the period that the bench computes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CONTROL = 2'd1,
    SEL_RELOAD = 2'd2,
    SEL_LIVE = 2'd3
  } reg_sel_e;

  localparam int CTL_IRQ_EN = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_GO = 2;
  localparam int CTL_HALT = 3;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_RUNNING = 1;

  // Two live status bits, packed in register order
  function automatic logic [1:0] status_bits(input logic running, input logic timeout);
    return {running, timeout};
  endfunction

  // Halt has priority over go; with neither, keep the present state
  function automatic logic run_after_ctl(input logic now, input logic go, input logic halt);
    if (halt) return 1'b0;
    if (go) return 1'b1;
    return now;
  endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic               re,
  output logic               wr_status,
  output logic               wr_control,
  output logic               wr_reload,
  output logic               rd_hit,
  output tmr_pkg::reg_sel_e  rd_sel
);
  localparam int LOW_BITS = 2;
  localparam int WIN_BITS = 4;

  logic in_window;
  logic aligned;
  tmr_pkg::reg_sel_e sel;

  assign aligned = (addr[LOW_BITS-1:0] == '0);
  assign sel     = tmr_pkg::reg_sel_e'(addr[WIN_BITS-1:LOW_BITS]);

  generate
    if (ADDR_W > WIN_BITS) begin : g_upper
      assign in_window = aligned && (addr[ADDR_W-1:WIN_BITS] == '0);
    end else begin : g_flat
      assign in_window = aligned;
    end
  endgenerate

  assign wr_status  = we && in_window && (sel == tmr_pkg::SEL_STATUS);
  assign wr_control = we && in_window && (sel == tmr_pkg::SEL_CONTROL);
  assign wr_reload  = we && in_window && (sel == tmr_pkg::SEL_RELOAD);
  assign rd_hit     = re && in_window;
  assign rd_sel     = sel;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_status,
  input  logic              wr_control,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] reload_q,
  output logic              timeout_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      timeout_q <= 1'b0;
    end else begin
      if (wr_control) ctrl_q <= wdata;
      if (wr_reload) reload_q <= wdata;
      // an expiry in the acknowledge cycle must not be lost
      if (expire) timeout_q <= 1'b1;
      else if (wr_status) timeout_q <= 1'b0;
    end
  end

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> timeout_q);

  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status && !expire |=> !timeout_q);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_q && !wr_status |=> timeout_q);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_control,
  input  logic              go_req,
  input  logic              halt_req,
  input  logic              wr_reload,
  input  logic [DATA_W-1:0] wdata,
  input  logic              auto_mode,
  input  logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] count_q,
  output logic              running_q,
  output logic              expire
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] TWO = DATA_W'(2);

  function automatic logic at_end(input logic [DATA_W-1:0] c);
    return c < TWO;
  endfunction

  function automatic logic [DATA_W-1:0] step_down(input logic [DATA_W-1:0] c);
    return c - ONE;
  endfunction

  logic halt_now;
  logic tick;

  assign halt_now = wr_control && halt_req;
  assign tick     = running_q && !halt_now;
  assign expire   = tick && at_end(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q   <= '0;
      running_q <= 1'b0;
    end else begin
      if (wr_reload) count_q <= wdata;
      else if (expire) count_q <= auto_mode ? reload_q : '0;
      else if (tick) count_q <= step_down(count_q);

      if (wr_control) running_q <= tmr_pkg::run_after_ctl(running_q, go_req, halt_req);
      else if (expire && !auto_mode) running_q <= 1'b0;
    end
  end

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running_q && !wr_control && !wr_reload && count_q > ONE |=> count_q == $past(count_q) - ONE);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running_q && !wr_reload |=> $stable(count_q));

  assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !auto_mode && !wr_reload && !wr_control |=> !running_q && count_q == '0);

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    expire && auto_mode && !wr_reload && !wr_control |=> running_q && count_q == $past(reload_q));

  assert_halt_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_control && halt_req |=> !running_q);

  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reload |=> count_q == $past(wdata));
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  tmr_pkg::reg_sel_e rd_sel,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] reload_q,
  input  logic [DATA_W-1:0] count_q,
  input  logic              running_q,
  input  logic              timeout_q,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] status_word;
  logic [DATA_W-1:0] picked;

  always_comb begin
    status_word = '0;
    status_word[tmr_pkg::ST_RUNNING:tmr_pkg::ST_TIMEOUT] = tmr_pkg::status_bits(running_q, timeout_q);
  end

  always_comb begin
    case (rd_sel)
      tmr_pkg::SEL_STATUS:  picked = status_word;
      tmr_pkg::SEL_CONTROL: picked = ctrl_q;
      tmr_pkg::SEL_RELOAD:  picked = reload_q;
      default:              picked = count_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else rdata <= rd_hit ? picked : '0;
  end
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic wr_status, wr_control, wr_reload, rd_hit;
  tmr_pkg::reg_sel_e rd_sel;
  logic [DATA_W-1:0] ctrl_q, reload_q, count_q;
  logic timeout_q, running_q, expire;

  tmr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr(bus_addr), .we(bus_we), .re(bus_re),
    .wr_status(wr_status), .wr_control(wr_control), .wr_reload(wr_reload),
    .rd_hit(rd_hit), .rd_sel(rd_sel)
  );

  tmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_status(wr_status), .wr_control(wr_control), .wr_reload(wr_reload),
    .wdata(bus_wdata), .expire(expire),
    .ctrl_q(ctrl_q), .reload_q(reload_q), .timeout_q(timeout_q)
  );

  tmr_count #(.DATA_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .wr_control(wr_control),
    .go_req(bus_wdata[tmr_pkg::CTL_GO]), .halt_req(bus_wdata[tmr_pkg::CTL_HALT]),
    .wr_reload(wr_reload), .wdata(bus_wdata),
    .auto_mode(ctrl_q[tmr_pkg::CTL_AUTO]), .reload_q(reload_q),
    .count_q(count_q), .running_q(running_q), .expire(expire)
  );

  tmr_readback #(.DATA_W(DATA_W)) u_readback (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .rd_sel(rd_sel),
    .ctrl_q(ctrl_q), .reload_q(reload_q), .count_q(count_q),
    .running_q(running_q), .timeout_q(timeout_q), .rdata(bus_rdata)
  );

  assign irq_o = timeout_q & ctrl_q[tmr_pkg::CTL_IRQ_EN];

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !rd_hit |=> bus_rdata == '0);

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> bus_rdata == '0);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status && !expire |=> !irq_o);
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic rd_pend = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  interval_timer #(.ADDR_W(8), .DATA_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  function automatic void check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endfunction

  // value left in the counter j edges after an auto-reload start with reload p
  function automatic logic [31:0] auto_pos(input int p, input int j);
    return 32'(p - ((j - 1) % p));
  endfunction

  // monitor: pops one expectation per completed read
  always @(posedge clk) rd_pend <= bus_re;
  always @(negedge clk) begin
    if (rd_pend) begin
      if (exp_q.size() == 0) check(bus_rdata, 32'hxxxx_xxxx, "R2 unexpected read data");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_addr = a; bus_re = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    check({31'b0, irq_o}, 32'd0, "R1 irq after reset");
    check(bus_rdata, 32'd0, "R1 rdata after reset");
    bus_rd(8'h00, 32'd0, "R1 status");
    bus_rd(8'h04, 32'd0, "R1 control");
    bus_rd(8'h08, 32'd0, "R1 reload");
    bus_rd(8'h0C, 32'd0, "R1 live count");

    // R12: start from zero count
    bus_wr(8'h04, 32'h4);
    bus_rd(8'h00, 32'h2, "R12 running before expiry");
    bus_rd(8'h00, 32'h1, "R12 expired next clock");
    bus_rd(8'h0C, 32'h0, "R7 one-shot holds zero");
    bus_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h00, 32'h0, "R9 status write clears flag");

    // R3: full control readback, no strobes
    bus_wr(8'h04, 32'hFFFF_FFF3);
    check({31'b0, irq_o}, 32'd0, "R10 enable without flag");
    bus_rd(8'h04, 32'hFFFF_FFF3, "R3 control readback");
    bus_rd(8'h00, 32'h0, "R3 no strobe keeps halted");

    // R4/R5 load, count down, halt
    bus_wr(8'h08, 32'd100);
    bus_rd(8'h0C, 32'd100, "R4 reload loads counter");
    bus_wr(8'h04, 32'h4);
    idle(5);
    bus_rd(8'h0C, 32'd95, "R5 one step per clock");
    bus_wr(8'h04, 32'h8);
    idle(3);
    bus_rd(8'h0C, 32'd94, "R3 halt freezes count");
    bus_rd(8'h00, 32'h0, "R3 halt clears running");
    bus_wr(8'h04, 32'hC);
    bus_rd(8'h00, 32'h0, "R3 halt wins over start");
    bus_rd(8'h0C, 32'd94, "R3 count unchanged");

    // R11 and R2: ignored writes
    bus_wr(8'h0C, 32'h1234);
    bus_rd(8'h0C, 32'd94, "R11 live count write ignored");
    bus_wr(8'h10, 32'd55);
    bus_wr(8'h09, 32'd77);
    bus_rd(8'h10, 32'd0, "R2 unmapped reads zero");
    bus_rd(8'h09, 32'd0, "R2 misaligned reads zero");
    bus_rd(8'h08, 32'd100, "R2 stray writes no effect");

    // R6/R7/R10 one-shot with interrupt
    bus_wr(8'h08, 32'd3);
    bus_wr(8'h04, 32'h5);
    idle(4);
    check({31'b0, irq_o}, 32'd1, "R10 irq on expiry");
    bus_rd(8'h00, 32'h1, "R6 flag set, halted");
    bus_rd(8'h0C, 32'h0, "R7 one-shot ends at zero");
    bus_wr(8'h00, 32'h0);
    check({31'b0, irq_o}, 32'd0, "R10 irq drops on clear");

    // R8 auto-reload, period 3
    bus_wr(8'h08, 32'd3);
    bus_wr(8'h04, 32'h6);
    for (int j = 1; j <= 6; j++) bus_rd(8'h0C, auto_pos(3, j), "R8 reload sequence");
    bus_rd(8'h00, 32'h3, "R8 flag set, still running");
    check({31'b0, irq_o}, 32'd0, "R10 no irq when disabled");
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, 32'h2, "R9 clear keeps running bit");
    bus_wr(8'h04, 32'h1);
    check({31'b0, irq_o}, 32'd1, "R10 enable with flag raises irq");
    bus_wr(8'h04, 32'h8);
    bus_wr(8'h00, 32'h0);

    // R9 hard case: acknowledge in the expiry cycle
    bus_wr(8'h08, 32'd3);
    bus_wr(8'h04, 32'h4);
    idle(2);
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h00, 32'h1, "R9 expiry beats clear");

    idle(2);
    check(32'(exp_q.size()), 32'd0, "R2 all reads answered");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule